// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received Ethernet frames, which arrive as a byte stream, into memory buffers. Software describes the buffers through a ring of descriptors in memory. Each descriptor names one buffer. For every frame, the engine does four things in order. It fetches the descriptor at its produce index. It packs the bytes into 32-bit word writes with byte enables. It writes a two-word status entry into a separate status array that uses the same ring index. It then advances the produce index and pulses a frame-done output.

Software owns the consume index. Software reads the produce index, handles each entry between the consume and produce indexes, and frees entries by advancing the consume index. The engine keeps the entry just behind the consume index unused, so a full ring can be told apart from an empty one. A frame that arrives while the ring is full is swallowed whole and raises a sticky overrun flag.

Top module: `rxr_ring_engine`

## Requirements
- R1: After reset, the produce index, the consume index, both base registers, the count register and the overrun flag are zero. The maximum-length register reads 1536. `in_ready` and `frame_done` are low.
- R2: Register word addresses:
  - 0: descriptor base
  - 1: status base
  - 2: entry count minus one
  - 3: produce index, read-only (writes are ignored)
  - 4: consume index
  - 5: maximum frame length
  - 6: flags, where bit 0 is overrun and writing 1 to bit 0 clears it
- R3: The descriptor for entry i sits at descriptor base + 8*i. Word 0 is the buffer pointer. Bits [10:0] of word 1 hold the buffer size minus one. `in_ready` stays low until both words have been read.
- R4: Frame byte k is stored at buffer pointer + k, in little-endian lane order, using 32-bit writes. A write's byte enables cover lanes 0 up to the last lane filled, so a final partial word enables only its lower lanes.
- R5: A frame stores at most min(buffer size, maximum length) bytes. Later bytes are accepted but never written to memory. For such a frame, bit 16 of the status info word is set.
- R6: The info word for entry i goes to status base + 8*i. Bits [10:0] hold the stored byte count minus one. Bit 16 is the truncation flag. All other bits are zero. The word at +4 is written as zero. Both status writes follow the last data write.
- R7: After the second status write, the produce index advances by one. It wraps to zero after reaching the count register value. `frame_done` pulses for one cycle, in the same cycle the new produce index becomes visible.
- R8: A frame is dropped when produce+1 (with wrap) equals the consume index. A dropped frame has all its bytes accepted, makes no memory access, and leaves the produce index unchanged. Dropping a frame sets the overrun flag, which is both bit 0 of register 6 and the `overrun` port.
- R9: Once software advances the consume index, a full ring accepts the next frame again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks last byte of frame |
| in_ready | output | 1 | Engine accepts the byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (else read) |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, one cycle after the read request |
| frame_done | output | 1 | One-cycle pulse per stored frame |
| overrun | output | 1 | Sticky dropped-frame flag |

## Verification
The main path is driven through a table of frames. Each row pairs a frame length with a buffer size and a maximum length, which separates four outcomes:
- frames of one, four and seven bytes, which exercise whole and partial word packing;
- frames cut by the buffer size;
- frames cut by the maximum length, including a limit that ends mid-word;
- frames that exactly fill their limit and must not be flagged as truncated.

Each buffer is prefilled with a known byte, so a byte written beyond the limit shows up as a changed guard byte. Eight frames on a four-entry ring carry the produce index through its wrap. A separate sequence fills the ring without freeing entries and shows that the next frame causes no memory write and no index change. It then clears the flag and frees one entry to show that reception resumes.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PTR,
        ST_CTL,
        ST_LIM,
        ST_DATA,
        ST_DROP,
        ST_INFO,
        ST_HASH
    } rx_state_e;

    localparam logic [2:0] RA_DESC_BASE = 3'd0;
    localparam logic [2:0] RA_STAT_BASE = 3'd1;
    localparam logic [2:0] RA_COUNT     = 3'd2;
    localparam logic [2:0] RA_PRODUCE   = 3'd3;
    localparam logic [2:0] RA_CONSUME   = 3'd4;
    localparam logic [2:0] RA_MAXLEN    = 3'd5;
    localparam logic [2:0] RA_FLAGS     = 3'd6;

    localparam int TRUNC_BIT = 16;

endpackage

// File: rtl/rxr_regs.sv
module rxr_regs
    import rxr_pkg::*;
#(
    parameter int AW         = 32,
    parameter int IDX_W      = 8,
    parameter int CNT_W      = 12,
    parameter int MAXLEN_RST = 1536
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             prod_adv,
    input  logic [IDX_W-1:0] prod_next,
    input  logic             overrun_set,
    output logic [AW-1:0]    desc_base,
    output logic [AW-1:0]    stat_base,
    output logic [IDX_W-1:0] last_idx,
    output logic [IDX_W-1:0] prod_idx,
    output logic [IDX_W-1:0] cons_idx,
    output logic [CNT_W-1:0] max_len,
    output logic             overrun
);

    typedef struct packed {
        logic [AW-1:0]    desc_base;
        logic [AW-1:0]    stat_base;
        logic [IDX_W-1:0] last_idx;
        logic [IDX_W-1:0] prod;
        logic [IDX_W-1:0] cons;
        logic [CNT_W-1:0] max_len;
        logic             overrun;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (prod_adv) begin
            r_d.prod = prod_next;
        end
        if (reg_we) begin
            case (reg_addr)
                RA_DESC_BASE: r_d.desc_base = reg_wdata[AW-1:0];
                RA_STAT_BASE: r_d.stat_base = reg_wdata[AW-1:0];
                RA_COUNT:     r_d.last_idx  = reg_wdata[IDX_W-1:0];
                RA_CONSUME:   r_d.cons      = reg_wdata[IDX_W-1:0];
                RA_MAXLEN:    r_d.max_len   = reg_wdata[CNT_W-1:0];
                RA_FLAGS:     if (reg_wdata[0]) r_d.overrun = 1'b0;
                default:      ;
            endcase
        end
        // a drop in the same cycle as a clear keeps the flag set
        if (overrun_set) begin
            r_d.overrun = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.max_len <= CNT_W'(MAXLEN_RST);
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (reg_addr)
            RA_DESC_BASE: reg_rdata = 32'(r_q.desc_base);
            RA_STAT_BASE: reg_rdata = 32'(r_q.stat_base);
            RA_COUNT:     reg_rdata = 32'(r_q.last_idx);
            RA_PRODUCE:   reg_rdata = 32'(r_q.prod);
            RA_CONSUME:   reg_rdata = 32'(r_q.cons);
            RA_MAXLEN:    reg_rdata = 32'(r_q.max_len);
            RA_FLAGS:     reg_rdata = {31'b0, r_q.overrun};
            default:      reg_rdata = '0;
        endcase
    end

    assign desc_base = r_q.desc_base;
    assign stat_base = r_q.stat_base;
    assign last_idx  = r_q.last_idx;
    assign prod_idx  = r_q.prod;
    assign cons_idx  = r_q.cons;
    assign max_len   = r_q.max_len;
    assign overrun   = r_q.overrun;

endmodule

// File: rtl/rxr_ring_idx.sv
module rxr_ring_idx #(
    parameter int AW    = 32,
    parameter int IDX_W = 8
) (
    input  logic [AW-1:0]    desc_base,
    input  logic [AW-1:0]    stat_base,
    input  logic [IDX_W-1:0] last_idx,
    input  logic [IDX_W-1:0] prod_idx,
    input  logic [IDX_W-1:0] cons_idx,
    output logic [IDX_W-1:0] prod_next,
    output logic             ring_full,
    output logic [AW-1:0]    desc_addr,
    output logic [AW-1:0]    stat_addr
);

    // each ring entry occupies two 32-bit words in both arrays
    localparam int ENTRY_SHIFT = 3;

    logic [AW-1:0] entry_off;

    always_comb begin
        prod_next = (prod_idx == last_idx) ? '0 : prod_idx + 1'b1;
        ring_full = (prod_next == cons_idx);
        entry_off = AW'(prod_idx) << ENTRY_SHIFT;
        desc_addr = desc_base + entry_off;
        stat_addr = stat_base + entry_off;
    end

endmodule

// File: rtl/rxr_frame_fsm.sv
module rxr_frame_fsm
    import rxr_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LEN_W = 11,
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    output logic             in_ready,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [3:0]       mem_be,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata,
    input  logic [AW-1:0]    desc_addr,
    input  logic [AW-1:0]    stat_addr,
    input  logic             ring_full,
    input  logic [CNT_W-1:0] max_len,
    output logic             prod_adv,
    output logic             overrun_set,
    output logic             frame_done
);

    typedef struct packed {
        rx_state_e        st;
        logic [AW-1:0]    ptr;
        logic [CNT_W-1:0] limit;
        logic [CNT_W-1:0] cnt;
        logic [31:0]      wbuf;
        logic             trunc;
        logic             done;
    } fsm_t;

    fsm_t s_d, s_q;

    logic [1:0]       lane;
    logic [4:0]       lane_sh;
    logic [31:0]      merged;
    logic [CNT_W-1:0] buf_sz;
    logic [CNT_W-1:0] cnt_inc;
    logic [31:0]      info;
    logic [3:0]       lane_be;

    always_comb begin
        lane    = s_q.cnt[1:0];
        lane_sh = {lane, 3'b000};
        merged  = (s_q.wbuf & ~(32'hFF << lane_sh)) | ({24'b0, in_data} << lane_sh);
        cnt_inc = s_q.cnt + 1'b1;
        buf_sz  = CNT_W'(mem_rdata[LEN_W-1:0]) + 1'b1;
        case (lane)
            2'd0:    lane_be = 4'b0001;
            2'd1:    lane_be = 4'b0011;
            2'd2:    lane_be = 4'b0111;
            default: lane_be = 4'b1111;
        endcase
        info = '0;
        info[LEN_W-1:0] = s_q.cnt[LEN_W-1:0] - 1'b1;
        info[TRUNC_BIT] = s_q.trunc;
    end

    always_comb begin
        s_d         = s_q;
        s_d.done    = 1'b0;
        in_ready    = 1'b0;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = '0;
        mem_be      = '0;
        mem_wdata   = '0;
        prod_adv    = 1'b0;
        overrun_set = 1'b0;

        case (s_q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    if (ring_full) begin
                        s_d.st      = ST_DROP;
                        overrun_set = 1'b1;
                    end else begin
                        s_d.st = ST_PTR;
                    end
                end
            end
            ST_PTR: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr;
                s_d.st   = ST_CTL;
            end
            ST_CTL: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + AW'(4);
                s_d.ptr  = mem_rdata[AW-1:0];
                s_d.st   = ST_LIM;
            end
            ST_LIM: begin
                s_d.limit = (buf_sz < max_len) ? buf_sz : max_len;
                s_d.cnt   = '0;
                s_d.trunc = 1'b0;
                s_d.st    = ST_DATA;
            end
            ST_DATA: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    if (s_q.cnt < s_q.limit) begin
                        s_d.cnt  = cnt_inc;
                        s_d.wbuf = merged;
                        if (lane == 2'd3 || in_last || cnt_inc == s_q.limit) begin
                            mem_req   = 1'b1;
                            mem_we    = 1'b1;
                            mem_addr  = s_q.ptr + AW'({s_q.cnt[CNT_W-1:2], 2'b00});
                            mem_be    = lane_be;
                            mem_wdata = merged;
                        end
                    end else begin
                        s_d.trunc = 1'b1;
                    end
                    if (in_last) begin
                        s_d.st = ST_INFO;
                    end
                end
            end
            ST_DROP: begin
                in_ready = 1'b1;
                if (in_valid && in_last) begin
                    s_d.st = ST_IDLE;
                end
            end
            ST_INFO: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = stat_addr;
                mem_be    = 4'b1111;
                mem_wdata = info;
                s_d.st    = ST_HASH;
            end
            ST_HASH: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = stat_addr + AW'(4);
                mem_be    = 4'b1111;
                mem_wdata = '0;
                prod_adv  = 1'b1;
                s_d.done  = 1'b1;
                s_d.st    = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign frame_done = s_q.done;

endmodule

// File: rtl/rxr_ring_engine.sv
module rxr_ring_engine #(
    parameter int AW         = 32,
    parameter int IDX_W      = 8,
    parameter int LEN_W      = 11,
    parameter int MAXLEN_RST = 1536
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    output logic        in_ready,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [3:0]  mem_be,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    output logic        frame_done,
    output logic        overrun
);

    localparam int CNT_W = LEN_W + 1;

    logic [AW-1:0]    desc_base, stat_base, desc_addr, stat_addr;
    logic [IDX_W-1:0] last_idx, prod_idx, cons_idx, prod_next;
    logic [CNT_W-1:0] max_len;
    logic             ring_full, prod_adv, overrun_set;
    logic [AW-1:0]    fsm_addr;

    rxr_regs #(
        .AW(AW), .IDX_W(IDX_W), .CNT_W(CNT_W), .MAXLEN_RST(MAXLEN_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .prod_adv(prod_adv), .prod_next(prod_next), .overrun_set(overrun_set),
        .desc_base(desc_base), .stat_base(stat_base), .last_idx(last_idx),
        .prod_idx(prod_idx), .cons_idx(cons_idx), .max_len(max_len), .overrun(overrun)
    );

    rxr_ring_idx #(
        .AW(AW), .IDX_W(IDX_W)
    ) u_idx (
        .desc_base(desc_base), .stat_base(stat_base), .last_idx(last_idx),
        .prod_idx(prod_idx), .cons_idx(cons_idx), .prod_next(prod_next),
        .ring_full(ring_full), .desc_addr(desc_addr), .stat_addr(stat_addr)
    );

    rxr_frame_fsm #(
        .AW(AW), .LEN_W(LEN_W), .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(fsm_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .desc_addr(desc_addr), .stat_addr(stat_addr), .ring_full(ring_full),
        .max_len(max_len), .prod_adv(prod_adv), .overrun_set(overrun_set),
        .frame_done(frame_done)
    );

    assign mem_addr = 32'(fsm_addr);

endmodule

// File: rtl/rxr_ring_engine_chk.sv
module rxr_ring_engine_chk #(
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             mem_req,
    input logic             mem_we,
    input logic [3:0]       mem_be,
    input logic             frame_done,
    input logic             overrun,
    input logic [IDX_W-1:0] prod_idx,
    input logic             ring_full
);

    // R3: no stream byte is taken while a descriptor word is being fetched
    assert_no_ready_in_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> !in_ready);

    // R4: write enables always start at lane 0 and are contiguous
    assert_lane_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_be == 4'b0001 || mem_be == 4'b0011 ||
                                 mem_be == 4'b0111 || mem_be == 4'b1111));

    // R7: frame completion is a single-cycle pulse
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R7: the produce index only moves together with a completion pulse
    assert_prod_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_idx != $past(prod_idx)) |-> frame_done);

    // R7: each advance is a step of one or a wrap to zero
    assert_prod_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (prod_idx == '0 || prod_idx == IDX_W'($past(prod_idx) + 1'b1)));

    // R8: the overrun flag rises only after the ring was seen full
    assert_overrun_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(ring_full));

endmodule

bind rxr_ring_engine rxr_ring_engine_chk #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .mem_req(mem_req),
    .mem_we(mem_we), .mem_be(mem_be), .frame_done(frame_done), .overrun(overrun),
    .prod_idx(prod_idx), .ring_full(ring_full)
);

// File: tb/rxr_ring_engine_tb.sv
module rxr_ring_engine_tb;

    localparam logic [31:0] DESC_BASE = 32'h100;
    localparam logic [31:0] STAT_BASE = 32'h200;
    localparam logic [31:0] BUF_BASE  = 32'h400;
    localparam int          RING_N    = 4;

    // fields: len[47:36] ctrl[35:24] maxlen[23:12] exp_stored[11:1] exp_trunc[0]
    localparam int NVEC = 8;
    localparam logic [47:0] VEC [NVEC] = '{
        {12'd1,  12'd255, 12'd1536, 11'd1,  1'b0},
        {12'd4,  12'd255, 12'd1536, 11'd4,  1'b0},
        {12'd7,  12'd255, 12'd1536, 11'd7,  1'b0},
        {12'd64, 12'd31,  12'd1536, 11'd32, 1'b1},
        {12'd50, 12'd255, 12'd20,   11'd20, 1'b1},
        {12'd13, 12'd12,  12'd1536, 11'd13, 1'b0},
        {12'd10, 12'd255, 12'd10,   11'd10, 1'b0},
        {12'd9,  12'd5,   12'd8,    11'd6,  1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic [31:0] mem_rdata = '0;
    logic        frame_done, overrun;

    int checks = 0;
    int errors = 0;
    int done_count = 0;
    int wr_count = 0;
    int exp_prod = 0;

    logic [31:0] mem [1024];

    always #10 clk = ~clk;

    rxr_ring_engine u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
        .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .frame_done(frame_done), .overrun(overrun)
    );

    always @(posedge clk) begin
        if (mem_req && mem_we) begin
            for (int b = 0; b < 4; b++) begin
                if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end
            wr_count <= wr_count + 1;
        end else if (mem_req) begin
            mem_rdata <= mem[mem_addr[11:2]];
        end
        if (frame_done) done_count <= done_count + 1;
    end

    function automatic logic [7:0] pat(input int fid, input int k);
        return 8'(fid * 29 + k * 3 + 1);
    endfunction

    function automatic logic [7:0] rd_byte(input logic [31:0] a);
        return mem[a[11:2]][8*a[1:0] +: 8];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic send_frame(input int fid, input int len);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = pat(fid, k); in_last = (k == len - 1);
            #1;
            while (!in_ready) begin
                @(negedge clk);
                #1;
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic run_frame(input int fid, input int len, input int ctrl, input int maxl,
                             input int exp_n, input logic exp_tr, input bit free_it);
        logic [31:0] bufa, rv;
        int start, waited, bad;
        reg_write(3'd5, 32'(maxl));
        bufa = BUF_BASE + 32'(exp_prod * 256);
        mem[(DESC_BASE >> 2) + 32'(2 * exp_prod)]     = bufa;
        mem[(DESC_BASE >> 2) + 32'(2 * exp_prod) + 1] = 32'(ctrl);
        mem[(STAT_BASE >> 2) + 32'(2 * exp_prod)]     = 32'hFFFF_FFFF;
        mem[(STAT_BASE >> 2) + 32'(2 * exp_prod) + 1] = 32'hFFFF_FFFF;
        for (int w = 0; w < 64; w++) mem[(bufa >> 2) + 32'(w)] = 32'hEEEE_EEEE;
        start = done_count;
        send_frame(fid, len);
        waited = 0;
        while (done_count == start && waited < 50) begin
            @(negedge clk);
            waited++;
        end
        chk("R7 frame_done seen", 32'(done_count - start), 32'd1);
        @(negedge clk);
        chk("R7 frame_done single cycle", 32'(frame_done), 32'd0);
        rv = mem[(STAT_BASE >> 2) + 32'(2 * exp_prod)];
        chk("R6 info length field", {21'b0, rv[10:0]}, 32'(exp_n - 1));
        chk("R5 truncation bit 16", 32'(rv[16]), 32'(exp_tr));
        chk("R6 info word whole", rv, (32'(exp_tr) << 16) | 32'(exp_n - 1));
        chk("R6 second status word zero", mem[(STAT_BASE >> 2) + 32'(2 * exp_prod) + 1], 32'd0);
        bad = 0;
        for (int k = 0; k < exp_n; k++) begin
            if (rd_byte(bufa + 32'(k)) !== pat(fid, k)) bad++;
        end
        chk("R4 stored bytes mismatches", 32'(bad), 32'd0);
        chk("R5 guard byte past limit", 32'(rd_byte(bufa + 32'(exp_n))), 32'hEE);
        exp_prod = (exp_prod + 1) % RING_N;
        reg_read(3'd3, rv);
        chk("R7 produce index", rv, 32'(exp_prod));
        if (free_it) reg_write(3'd4, 32'(exp_prod));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        int wr0, dn0;
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 in_ready", 32'(in_ready), 32'd0);
        chk("R1 frame_done", 32'(frame_done), 32'd0);
        chk("R1 overrun port", 32'(overrun), 32'd0);
        reg_read(3'd0, rv); chk("R1 desc base", rv, 32'd0);
        reg_read(3'd2, rv); chk("R1 count", rv, 32'd0);
        reg_read(3'd3, rv); chk("R1 produce", rv, 32'd0);
        reg_read(3'd4, rv); chk("R1 consume", rv, 32'd0);
        reg_read(3'd5, rv); chk("R1 max length", rv, 32'd1536);
        reg_read(3'd6, rv); chk("R1 flags", rv, 32'd0);

        // R2 register map
        reg_write(3'd0, DESC_BASE);
        reg_write(3'd1, STAT_BASE);
        reg_write(3'd2, 32'(RING_N - 1));
        reg_read(3'd0, rv); chk("R2 desc base readback", rv, DESC_BASE);
        reg_read(3'd1, rv); chk("R2 status base readback", rv, STAT_BASE);
        reg_read(3'd2, rv); chk("R2 count readback", rv, 32'(RING_N - 1));
        reg_write(3'd3, 32'd2);
        reg_read(3'd3, rv); chk("R2 produce is read-only", rv, 32'd0);

        // R3 R4 R5 R6 R7: table of frames, wraps the ring twice
        for (int v = 0; v < NVEC; v++) begin
            run_frame(v + 1, int'(VEC[v][47:36]), int'(VEC[v][35:24]), int'(VEC[v][23:12]),
                      int'(VEC[v][11:1]), VEC[v][0], 1'b1);
        end
        chk("R7 produce wrapped to zero", 32'(exp_prod), 32'd0);

        // R8: fill the ring without freeing entries
        for (int f = 0; f < RING_N - 1; f++) begin
            run_frame(20 + f, 5, 255, 1536, 5, 1'b0, 1'b0);
        end
        wr0 = wr_count;
        dn0 = done_count;
        mem[(STAT_BASE >> 2) + 32'(2 * exp_prod)] = 32'hFFFF_FFFF;
        send_frame(30, 6);
        repeat (10) @(negedge clk);
        chk("R8 no memory write on drop", 32'(wr_count - wr0), 32'd0);
        chk("R8 no frame_done on drop", 32'(done_count - dn0), 32'd0);
        chk("R8 status entry untouched", mem[(STAT_BASE >> 2) + 32'(2 * exp_prod)], 32'hFFFF_FFFF);
        reg_read(3'd3, rv); chk("R8 produce unchanged", rv, 32'(exp_prod));
        chk("R8 overrun port set", 32'(overrun), 32'd1);
        reg_read(3'd6, rv); chk("R8 overrun flag bit0", rv, 32'd1);
        reg_write(3'd6, 32'd1);
        reg_read(3'd6, rv); chk("R8 overrun cleared by write", rv, 32'd0);
        chk("R8 overrun port cleared", 32'(overrun), 32'd0);

        // R9: free one entry and receive again
        reg_write(3'd4, 32'd1);
        run_frame(40, 11, 255, 1536, 11, 1'b0, 1'b0);
        chk("R9 frame accepted after consume advance", 32'(overrun), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule